// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block drives and samples 96 general-purpose pins, arranged as three banks of 32. A single-cycle register port gives software a direction word, an input-polarity word and an output-latch word per bank. It also gives two write-one-to-act words per bank, which raise or drop chosen output bits without a read-modify-write sequence. Words of the same kind sit side by side for all banks inside one 16-byte group, with 4 bytes between banks. So a bank's word lives at group base + 4 × bank.

Pin inputs pass through a two-flop synchronizer. The synchronized value is then XORed with the bank's polarity word. The result is reported on a data-word read for pins configured as inputs. It is also presented on `pin_level` for a separate interrupt-detection block. Output pins report their latch value on a data-word read. Reads are registered: `reg_rd_data` shows the word addressed at a clock edge from that edge onward. A write takes effect at the edge that samples it.

The register port is a plain control interface: there is no back-pressure, and an access is accepted every cycle.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), every output latch is 0, every polarity bit is 0, and `reg_rd_data` is 0.
- R2: The direction word of bank b is at byte address 0x00 + 4·b. A 1 in bit i drives `pin_oe[32·b+i]` high (output) and a 0 makes it an input. The word reads back as written. No other write changes `pin_oe`.
- R3: The data word of bank b is at 0x20 + 4·b. Writing it loads the output latch, which appears on `pin_out[32·b+31:32·b]` from the edge that samples the write. `pin_out` changes only on a register write.
- R4: Writing the set word of bank b (0x30 + 4·b) makes each latch bit whose write-data bit is 1 become 1. Bits written 0 are unchanged.
- R5: Writing the clear word of bank b (0x40 + 4·b) makes each latch bit whose write-data bit is 1 become 0. Bits written 0 are unchanged.
- R6: The set and clear words always read as 0.
- R7: A data-word read returns, per bit, the output latch where the direction bit is 1. Where the direction bit is 0, it returns the synchronized, polarity-adjusted pin input. A change on `pin_in` reaches `pin_level` after exactly two rising edges.
- R8: The polarity word of bank b is at 0x10 + 4·b and reads back as written. A 1 inverts that pin's input on `pin_level` and in the data-word read. Polarity never alters `pin_out`.
- R9: The following addresses read as 0, and writes to them change nothing: a group offset above 0x40, a bank index of 3 or more, or a non-zero value in address bits [1:0].
- R10: A write to a word of bank b changes only the pins and state of bank b.
- R11: `reg_rd_data` reflects the word at the address sampled on the previous edge. This includes a write committed at an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe, one word per cycle |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Registered read data |
| pin_in | input | 96 | Raw pin inputs |
| pin_out | output | 96 | Output drive value per pin |
| pin_oe | output | 96 | Output enable per pin |
| pin_level | output | 96 | Synchronized, polarity-adjusted input level |

## Verification
The bench targets several failure modes:
- Set and clear words that touch zero bits. A design that writes the word directly instead of OR-ing or AND-NOT-ing would wipe the other latch bits.
- Set or clear words that read back as the latch.
- Mixed-direction data reads. Muxing the wrong way would return input values for output pins.
- Polarity leaking into the output path.
- Synchronizer latency off by one edge, which shows up as `pin_level` changing after the first edge.
- Aliasing. Writes to bank index 3, to unused groups, or to misaligned addresses must leave every pin untouched. A decoder that ignored those address bits would corrupt a real bank.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    GRP_DIR  = 3'd0,
    GRP_POL  = 3'd1,
    GRP_DATA = 3'd2,
    GRP_SET  = 3'd3,
    GRP_CLR  = 3'd4
  } reg_grp_e;

  localparam int unsigned LAST_GRP = 4;

  typedef struct packed {
    logic       hit;
    reg_grp_e   grp;
    logic [1:0] bank;
  } reg_acc_t;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_acc_t          acc
);
  localparam int unsigned GF_W = ADDR_W - 4;

  logic [GF_W-1:0] grp_field;
  logic            grp_ok;
  logic            bank_ok;
  logic            align_ok;

  always_comb begin
    grp_field = addr[ADDR_W-1:4];
    grp_ok    = grp_field <= GF_W'(LAST_GRP);
    bank_ok   = {1'b0, addr[3:2]} < 3'(NUM_BANKS);
    align_ok  = addr[1:0] == 2'b00;
    acc.hit   = grp_ok && bank_ok && align_ok;
    acc.grp   = reg_grp_e'(grp_field[2:0]);
    acc.bank  = addr[3:2];
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  reg_grp_e         grp,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] sync_in,
  output logic [WIDTH-1:0] dir,
  output logic [WIDTH-1:0] latch,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pol_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (wr_sel) begin
      case (grp)
        GRP_DATA: latch_d = wr_data;
        GRP_SET:  latch_d = latch_q | wr_data;
        GRP_CLR:  latch_d = latch_q & ~wr_data;
        default:  latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pol_q   <= '0;
      latch_q <= '0;
    end else begin
      latch_q <= latch_d;
      if (wr_sel && grp == GRP_DIR) dir_q <= wr_data;
      if (wr_sel && grp == GRP_POL) pol_q <= wr_data;
    end
  end

  assign level = sync_in ^ pol_q;
  assign dir   = dir_q;
  assign latch = latch_q;

  always_comb begin
    case (grp)
      GRP_DIR:  rd_word = dir_q;
      GRP_POL:  rd_word = pol_q;
      GRP_DATA: rd_word = (dir_q & latch_q) | (~dir_q & level);
      default:  rd_word = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_wr_en,
  input  logic [BANK_W-1:0]           reg_wr_data,
  output logic [BANK_W-1:0]           reg_rd_data,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
  output logic [NUM_BANKS*BANK_W-1:0] pin_out,
  output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
  output logic [NUM_BANKS*BANK_W-1:0] pin_level
);
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W;

  reg_acc_t          acc;
  logic [NUM_PINS-1:0] sync_all;
  logic [BANK_W-1:0] bank_rd [NUM_BANKS];
  logic [BANK_W-1:0] rd_next;
  logic [BANK_W-1:0] rd_q;

  gpio_reg_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS)
  ) dec_i (
    .addr(reg_addr),
    .acc (acc)
  );

  gpio_in_sync #(
    .WIDTH(NUM_PINS)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (pin_in),
    .synced(sync_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = reg_wr_en && acc.hit && (acc.bank == 2'(b));

    gpio_bank_regs #(
      .WIDTH(BANK_W)
    ) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (sel),
      .grp    (acc.grp),
      .wr_data(reg_wr_data),
      .sync_in(sync_all[b*BANK_W +: BANK_W]),
      .dir    (pin_oe[b*BANK_W +: BANK_W]),
      .latch  (pin_out[b*BANK_W +: BANK_W]),
      .level  (pin_level[b*BANK_W +: BANK_W]),
      .rd_word(bank_rd[b])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (acc.hit && acc.bank == 2'(b)) rd_next = rd_next | bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_next;
  end

  assign reg_rd_data = rd_q;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic                        reg_wr_en,
  input logic [BANK_W-1:0]           reg_rd_data,
  input logic [NUM_BANKS*BANK_W-1:0] pin_out,
  input logic [NUM_BANKS*BANK_W-1:0] pin_oe
);
  logic [ADDR_W-5:0] gf;
  logic valid_addr, is_dir, is_set, is_clr;

  always_comb begin
    gf         = reg_addr[ADDR_W-1:4];
    valid_addr = (reg_addr[1:0] == 2'b00) && ({1'b0, reg_addr[3:2]} < 3'(NUM_BANKS))
                 && (gf < (ADDR_W-4)'(5));
    is_dir     = valid_addr && gf == '0;
    is_set     = valid_addr && gf == (ADDR_W-4)'(3);
    is_clr     = valid_addr && gf == (ADDR_W-4)'(4);
  end

  AST_OE_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(pin_oe)); // R2
  AST_OE_ONLY_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !is_dir) |=> $stable(pin_oe)); // R2
  AST_OUT_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(pin_out)); // R3
  AST_SET_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && is_set) |=> (($past(pin_out) & ~pin_out) == '0)); // R4
  AST_CLR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && is_clr) |=> ((pin_out & ~$past(pin_out)) == '0)); // R5
  AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_set || is_clr) |=> (reg_rd_data == '0)); // R6
  AST_UNDEC_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_addr |=> (reg_rd_data == '0)); // R9
  AST_UNDEC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !valid_addr) |=> ($stable(pin_out) && $stable(pin_oe))); // R9
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr_en  (reg_wr_en),
  .reg_rd_data(reg_rd_data),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;
  localparam int NP = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr_en = 1'b0;
  logic [31:0]   reg_wr_data = '0;
  logic [31:0]   reg_rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_level;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_level(pin_level)
  );

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 d = reg_rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rd_data", {64'h0, reg_rd_data}, '0);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    reg_read(8'h14, d); check("R1 polarity", {64'h0, d}, '0);
    reg_read(8'h08, d); check("R1 dir", {64'h0, d}, '0);
  endtask

  task automatic t_dir();
    logic [31:0] d;
    reg_write(8'h04, 32'hA5A5_0F0F);
    check("R2 R10 pin_oe bank1", pin_oe, {32'h0, 32'hA5A5_0F0F, 32'h0});
    reg_read(8'h04, d); check("R2 dir readback", {64'h0, d}, {64'h0, 32'hA5A5_0F0F});
  endtask

  task automatic t_data();
    logic [31:0] d;
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_write(8'h20, 32'h1234_5678);
    check("R3 R10 pin_out bank0", pin_out, {64'h0, 32'h1234_5678});
    reg_read(8'h20, d); check("R3 data read output pins", {64'h0, d}, {64'h0, 32'h1234_5678});
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    reg_write(8'h28, 32'h0000_FFFF);
    reg_write(8'h38, 32'hFF00_0F00);
    check("R4 set bank2", pin_out[95:64], {64'h0, 32'hFF00_FFFF});
    reg_write(8'h48, 32'h0F00_00F0);
    check("R5 clear bank2", pin_out, {32'hF000_FF0F, 32'h0, 32'h1234_5678});
    reg_read(8'h38, d); check("R6 set reads 0", {64'h0, d}, '0);
    reg_read(8'h48, d); check("R6 clear reads 0", {64'h0, d}, '0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pin_in[95:64] = 32'hCAFE_BABE;
    @(posedge clk); #1;
    check("R7 level after one edge", pin_level[95:64], '0);
    @(posedge clk); #1;
    check("R7 level after two edges", pin_level[95:64], {64'h0, 32'hCAFE_BABE});
    reg_read(8'h28, d); check("R7 data read inputs", {64'h0, d}, {64'h0, 32'hCAFE_BABE});
    reg_write(8'h08, 32'hFFFF_0000);
    reg_read(8'h28, d); check("R7 data read mixed", {64'h0, d}, {64'h0, 32'hF000_BABE});
  endtask

  task automatic t_pol();
    logic [31:0] d;
    reg_write(8'h18, 32'h0000_FFFF);
    reg_read(8'h18, d); check("R8 pol readback", {64'h0, d}, {64'h0, 32'h0000_FFFF});
    check("R8 level inverted", pin_level[95:64], {64'h0, 32'hCAFE_4541});
    reg_read(8'h28, d); check("R8 data read inverted", {64'h0, d}, {64'h0, 32'hF000_4541});
    check("R8 pin_out untouched", pin_out, {32'hF000_FF0F, 32'h0, 32'h1234_5678});
  endtask

  task automatic t_undec();
    logic [31:0] d;
    logic [NP-1:0] exp_out, exp_oe;
    exp_out = {32'hF000_FF0F, 32'h0, 32'h1234_5678};
    exp_oe  = {32'hFFFF_0000, 32'hA5A5_0F0F, 32'hFFFF_FFFF};
    reg_write(8'h50, 32'hFFFF_FFFF);
    reg_write(8'h0C, 32'h0000_0000);
    reg_write(8'h2C, 32'h0000_0000);
    reg_write(8'h21, 32'h0000_0000);
    reg_write(8'hF0, 32'h0000_0000);
    check("R9 pin_out after undecoded writes", pin_out, exp_out);
    check("R9 pin_oe after undecoded writes", pin_oe, exp_oe);
    reg_read(8'h50, d); check("R9 unused group reads 0", {64'h0, d}, '0);
    reg_read(8'h0C, d); check("R9 bank3 reads 0", {64'h0, d}, '0);
    reg_read(8'h02, d); check("R9 misaligned reads 0", {64'h0, d}, '0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    reg_write(8'h14, 32'h0000_0001);
    reg_read(8'h14, d); check("R11 read after write", {64'h0, d}, {64'h0, 32'h1});
    @(negedge clk); reg_addr = 8'h04;
    @(posedge clk); #1;
    check("R11 rd follows sampled addr", {64'h0, reg_rd_data}, {64'h0, 32'hA5A5_0F0F});
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_dir();
    t_data();
    t_setclr();
    t_input();
    t_pol();
    t_undec();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule